// File: doc/BRIEF.md
# HDLC Receive Deframer

This block is the bit-level front end of an HDLC/SDLC receiver. It takes one serial bit per accepted handshake and keeps a running count of consecutive ones. From that count it makes every framing decision. A zero that follows five ones is a stuffed zero and is removed. Six ones closed by a zero form a flag, which marks a frame boundary. A seventh one in a row ends the frame. In normal mode that is an abort, and in loop mode it is an end-of-poll.

After reset, and after any abort or end-of-poll, the block hunts for a flag and discards everything it receives. Once a flag has been seen, the destuffed bits come out as a strobed bit stream and are also packed into bytes aligned to that flag. Flag bits never reach either output, because the data passes through a short alignment delay that is cleared when a flag is recognised. A frame that closes on something other than a byte boundary is reported as a residue, together with the number of leftover bits.

Bytes leave through a valid/ready port. While a completed byte has not been taken, the block lowers `in_ready`, so the serial source is held back rather than a byte being dropped. Control and status outputs are plain registered signals.

Top module: `hdlc_rx_deframer`

## Requirements
- R1: After reset, `hunting` is 1, `in_ready` is 1, and `byte_valid`, `abort_active`, `flag_seen`, `eop_seen` and `dbit_valid` are all 0.
- R2: An input 0 that directly follows exactly five consecutive input 1s is deleted. It appears neither on `dbit` nor in any byte.
- R3: An input 0 that follows exactly six consecutive 1s (the flag 01111110) causes a `flag_seen` pulse one cycle after it is accepted, and `hunting` goes to 0.
- R4: In normal mode (`loop_mode` = 0), a seventh consecutive 1 sets `abort_active` and `hunting`. `abort_active` stays 1 through any longer run of ones and clears on the next accepted 0.
- R5: In loop mode (`loop_mode` = 1), a seventh consecutive 1 produces one `eop_seen` pulse, sets `hunting`, and leaves `abort_active` at 0.
- R6: While hunting, no bit is emitted on `dbit_valid` and no byte is produced.
- R7: Once a flag has been seen, every eight destuffed bits form one byte, with the first bit received in bit 0. Back-to-back flags produce no byte.
- R8: When a flag arrives while 1 to 7 bits of an unfinished byte are held, `residue_valid` pulses together with `flag_seen`, and `residue_bits` gives that bit count.
- R9: While `byte_valid` is 1 and `byte_ready` is 0, `byte_data` stays stable, `in_ready` is 0, and no further input bit is consumed.
- R10: Each destuffed data bit of a frame is emitted exactly once on `dbit`/`dbit_valid`. The bits of a flag, and the bits just before an abort or end-of-poll, are not emitted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| loop_mode | input | 1 | 1 selects end-of-poll reporting instead of abort |
| in_valid | input | 1 | Serial bit offered |
| in_ready | output | 1 | Serial bit can be taken this cycle |
| in_bit | input | 1 | Serial bit value |
| dbit_valid | output | 1 | Destuffed data bit strobe |
| dbit | output | 1 | Destuffed data bit |
| byte_valid | output | 1 | Assembled byte available |
| byte_ready | input | 1 | Consumer takes the byte |
| byte_data | output | BYTE_W | Assembled byte, first received bit in bit 0 |
| flag_seen | output | 1 | One-cycle pulse per flag |
| abort_active | output | 1 | Abort level, held while the ones run lasts |
| eop_seen | output | 1 | One-cycle end-of-poll pulse |
| hunting | output | 1 | Searching for a flag |
| residue_valid | output | 1 | One-cycle pulse for a partial byte at a flag |
| residue_bits | output | $clog2(BYTE_W) | Number of leftover bits in that partial byte |

## Verification
The checker watches, on every cycle, the invariants that relate outputs across time. A stalled byte must stay held and consume nothing. No data bit may be emitted while hunting, and flags, end-of-poll and data bits must never coincide. Abort may only be raised in normal mode and must clear on a zero. A residue always comes with a flag and a nonzero count. The newest data bit must land in the top bit of each byte.

Whether the right bits survive destuffing, whether bytes carry the right values, and whether the residue counts and the number of emitted bits are correct can only be shown by the bench. It does this with whole framed streams: stuffed bytes, back-to-back flags, leading junk, partial bytes, and long runs of ones in both modes.

// File: rtl/hdlc_rx_pkg.sv
package hdlc_rx_pkg;

  // Classification of one incoming bit against the current ones run.
  typedef enum logic [2:0] {
    EV_DATA,      // ordinary data bit (includes the sixth one)
    EV_STUFF,     // zero after five ones: deleted
    EV_FLAG,      // zero after six ones: flag complete
    EV_SEVENTH,   // seventh consecutive one: abort or end-of-poll
    EV_LONG_ONE,  // eighth or later one of a run
    EV_RUN_END    // zero closing a run of seven or more ones
  } bit_ev_e;

endpackage

// File: rtl/hdlc_ones_tracker.sv
module hdlc_ones_tracker
  import hdlc_rx_pkg::*;
#(
  parameter int STUFF_RUN = 5
) (
  input  logic    clk,
  input  logic    rst_n,
  input  logic    take,
  input  logic    din,
  output bit_ev_e ev
);
  localparam int FLAG_RUN  = STUFF_RUN + 1;
  localparam int ABORT_RUN = STUFF_RUN + 2;
  localparam int CW        = $clog2(ABORT_RUN + 1);

  logic [CW-1:0] ones_q;

  always_comb begin
    if (din) begin
      if (ones_q == CW'(FLAG_RUN))        ev = EV_SEVENTH;
      else if (ones_q >= CW'(ABORT_RUN))  ev = EV_LONG_ONE;
      else                                ev = EV_DATA;
    end else begin
      if (ones_q == CW'(STUFF_RUN))       ev = EV_STUFF;
      else if (ones_q == CW'(FLAG_RUN))   ev = EV_FLAG;
      else if (ones_q >= CW'(ABORT_RUN))  ev = EV_RUN_END;
      else                                ev = EV_DATA;
    end
  end

  // Saturating run counter; any zero restarts it.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ones_q <= '0;
    end else if (take) begin
      if (!din)                             ones_q <= '0;
      else if (ones_q < CW'(ABORT_RUN))     ones_q <= ones_q + CW'(1);
    end
  end

endmodule

// File: rtl/hdlc_align_delay.sv
module hdlc_align_delay #(
  parameter int DEPTH = 7
) (
  input  logic clk,
  input  logic rst_n,
  input  logic push,
  input  logic flush,
  input  logic din,
  output logic emit,
  output logic dout
);
  localparam int FW = $clog2(DEPTH + 1);

  logic [DEPTH-1:0] line_q;
  logic [FW-1:0]    fill_q;

  // A bit leaves only when a new one pushes it out of a full line.
  assign emit = push && (fill_q == FW'(DEPTH));
  assign dout = line_q[DEPTH-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      line_q <= '0;
      fill_q <= '0;
    end else if (flush) begin
      fill_q <= '0;
    end else if (push) begin
      line_q <= {line_q[DEPTH-2:0], din};
      if (fill_q != FW'(DEPTH)) fill_q <= fill_q + FW'(1);
    end
  end

endmodule

// File: rtl/hdlc_byte_asm.sv
module hdlc_byte_asm #(
  parameter int W         = 8,
  parameter bit LSB_FIRST = 1'b1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 shift,
  input  logic                 clear,
  input  logic                 din,
  output logic                 done,
  output logic [W-1:0]         word,
  output logic [$clog2(W)-1:0] count
);
  localparam int CW = $clog2(W);

  logic [W-1:0]  sr_q;
  logic [W-1:0]  sr_next;
  logic [CW-1:0] cnt_q;

  generate
    if (LSB_FIRST) begin : g_lsb
      assign sr_next = {din, sr_q[W-1:1]};
    end else begin : g_msb
      assign sr_next = {sr_q[W-2:0], din};
    end
  endgenerate

  assign done  = shift && (cnt_q == CW'(W - 1));
  assign word  = sr_next;
  assign count = cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr_q  <= '0;
      cnt_q <= '0;
    end else if (clear) begin
      cnt_q <= '0;
    end else if (shift) begin
      sr_q  <= sr_next;
      cnt_q <= done ? '0 : cnt_q + CW'(1);
    end
  end

endmodule

// File: rtl/hdlc_rx_deframer.sv
module hdlc_rx_deframer
  import hdlc_rx_pkg::*;
#(
  parameter int BYTE_W    = 8,
  parameter int STUFF_RUN = 5,
  parameter bit LSB_FIRST = 1'b1
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      loop_mode,
  input  logic                      in_valid,
  output logic                      in_ready,
  input  logic                      in_bit,
  output logic                      dbit_valid,
  output logic                      dbit,
  output logic                      byte_valid,
  input  logic                      byte_ready,
  output logic [BYTE_W-1:0]         byte_data,
  output logic                      flag_seen,
  output logic                      abort_active,
  output logic                      eop_seen,
  output logic                      hunting,
  output logic                      residue_valid,
  output logic [$clog2(BYTE_W)-1:0] residue_bits
);
  localparam int DELAY = STUFF_RUN + 2;   // leading zero plus six ones of a flag
  localparam int RES_W = $clog2(BYTE_W);

  bit_ev_e           ev;
  logic              take, is_flag, is_seventh, push, flush;
  logic              emit, dline_bit;
  logic              asm_done;
  logic [BYTE_W-1:0] asm_word;
  logic [RES_W-1:0]  asm_cnt;

  logic              hunt_q, abort_q, flag_q, eop_q, dval_q, dbit_q;
  logic              bval_q, res_q;
  logic [BYTE_W-1:0] byte_q;
  logic [RES_W-1:0]  res_bits_q;

  assign in_ready   = !bval_q || byte_ready;
  assign take       = in_valid && in_ready;
  assign is_flag    = take && (ev == EV_FLAG);
  assign is_seventh = take && (ev == EV_SEVENTH);
  assign push       = take && !hunt_q && (ev == EV_DATA);
  assign flush      = is_flag || is_seventh;

  hdlc_ones_tracker #(.STUFF_RUN(STUFF_RUN)) u_ones (
    .clk   (clk),
    .rst_n (rst_n),
    .take  (take),
    .din   (in_bit),
    .ev    (ev)
  );

  hdlc_align_delay #(.DEPTH(DELAY)) u_align (
    .clk   (clk),
    .rst_n (rst_n),
    .push  (push),
    .flush (flush),
    .din   (in_bit),
    .emit  (emit),
    .dout  (dline_bit)
  );

  hdlc_byte_asm #(.W(BYTE_W), .LSB_FIRST(LSB_FIRST)) u_asm (
    .clk   (clk),
    .rst_n (rst_n),
    .shift (emit),
    .clear (flush),
    .din   (dline_bit),
    .done  (asm_done),
    .word  (asm_word),
    .count (asm_cnt)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hunt_q     <= 1'b1;
      abort_q    <= 1'b0;
      flag_q     <= 1'b0;
      eop_q      <= 1'b0;
      dval_q     <= 1'b0;
      dbit_q     <= 1'b0;
      bval_q     <= 1'b0;
      byte_q     <= '0;
      res_q      <= 1'b0;
      res_bits_q <= '0;
    end else begin
      flag_q <= is_flag;
      eop_q  <= is_seventh && loop_mode;
      dval_q <= emit;
      if (emit) dbit_q <= dline_bit;

      res_q <= is_flag && !hunt_q && (asm_cnt != '0);
      if (is_flag) res_bits_q <= asm_cnt;

      if (is_flag)         hunt_q <= 1'b0;
      else if (is_seventh) hunt_q <= 1'b1;

      if (is_seventh && !loop_mode) abort_q <= 1'b1;
      else if (take && !in_bit)     abort_q <= 1'b0;

      if (asm_done) begin
        bval_q <= 1'b1;
        byte_q <= asm_word;
      end else if (byte_ready) begin
        bval_q <= 1'b0;
      end
    end
  end

  assign dbit_valid    = dval_q;
  assign dbit          = dbit_q;
  assign byte_valid    = bval_q;
  assign byte_data     = byte_q;
  assign flag_seen     = flag_q;
  assign abort_active  = abort_q;
  assign eop_seen      = eop_q;
  assign hunting       = hunt_q;
  assign residue_valid = res_q;
  assign residue_bits  = res_bits_q;

endmodule

// File: rtl/hdlc_rx_deframer_chk.sv
module hdlc_rx_deframer_chk #(
  parameter int BYTE_W    = 8,
  parameter bit LSB_FIRST = 1'b1
) (
  input logic                      clk,
  input logic                      rst_n,
  input logic                      loop_mode,
  input logic                      in_valid,
  input logic                      in_ready,
  input logic                      in_bit,
  input logic                      dbit_valid,
  input logic                      dbit,
  input logic                      byte_valid,
  input logic                      byte_ready,
  input logic [BYTE_W-1:0]         byte_data,
  input logic                      flag_seen,
  input logic                      abort_active,
  input logic                      eop_seen,
  input logic                      hunting,
  input logic                      residue_valid,
  input logic [$clog2(BYTE_W)-1:0] residue_bits
);

  p_flag_leaves_hunt_r3: assert property (@(posedge clk) disable iff (!rst_n)
    flag_seen |-> !hunting);

  p_abort_hunts_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(abort_active) |-> hunting);

  p_zero_clears_abort_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (abort_active && in_valid && in_ready && !in_bit) |=> !abort_active);

  p_loop_no_abort_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(abort_active) |-> $past(!loop_mode && in_valid && in_ready && in_bit));

  p_eop_not_abort_r5: assert property (@(posedge clk) disable iff (!rst_n)
    eop_seen |-> !abort_active);

  p_hunt_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
    hunting |-> !dbit_valid);

  p_last_bit_top_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(byte_valid) |-> (dbit_valid &&
      ((LSB_FIRST ? byte_data[BYTE_W-1] : byte_data[0]) == dbit)));

  p_residue_with_flag_r8: assert property (@(posedge clk) disable iff (!rst_n)
    residue_valid |-> (flag_seen && residue_bits != '0));

  p_hold_byte_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_valid && !byte_ready) |=> (byte_valid && $stable(byte_data)));

  p_stall_consumes_nothing_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_valid && !byte_ready) |=> (!flag_seen && !dbit_valid && !eop_seen));

  p_events_exclusive_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({flag_seen, eop_seen, dbit_valid}));

endmodule

bind hdlc_rx_deframer hdlc_rx_deframer_chk #(.BYTE_W(BYTE_W), .LSB_FIRST(LSB_FIRST)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .loop_mode     (loop_mode),
  .in_valid      (in_valid),
  .in_ready      (in_ready),
  .in_bit        (in_bit),
  .dbit_valid    (dbit_valid),
  .dbit          (dbit),
  .byte_valid    (byte_valid),
  .byte_ready    (byte_ready),
  .byte_data     (byte_data),
  .flag_seen     (flag_seen),
  .abort_active  (abort_active),
  .eop_seen      (eop_seen),
  .hunting       (hunting),
  .residue_valid (residue_valid),
  .residue_bits  (residue_bits)
);

// File: tb/tb_hdlc_rx_deframer.sv
module tb_hdlc_rx_deframer;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       loop_mode = 1'b0;
  logic       in_valid = 1'b0;
  logic       in_bit = 1'b0;
  logic       byte_ready = 1'b1;
  logic       in_ready, dbit_valid, dbit, byte_valid;
  logic [7:0] byte_data;
  logic       flag_seen, abort_active, eop_seen, hunting, residue_valid;
  logic [2:0] residue_bits;

  always #5 clk = ~clk;

  hdlc_rx_deframer dut (
    .clk(clk), .rst_n(rst_n), .loop_mode(loop_mode),
    .in_valid(in_valid), .in_ready(in_ready), .in_bit(in_bit),
    .dbit_valid(dbit_valid), .dbit(dbit),
    .byte_valid(byte_valid), .byte_ready(byte_ready), .byte_data(byte_data),
    .flag_seen(flag_seen), .abort_active(abort_active), .eop_seen(eop_seen),
    .hunting(hunting), .residue_valid(residue_valid), .residue_bits(residue_bits)
  );

  typedef struct packed {
    logic [63:0] stream;   // bit i is sent at step i
    logic [6:0]  nbits;
    logic        loop;
    logic [3:0]  flags;
    logic [3:0]  bytes;
    logic [7:0]  last;
    logic [1:0]  aborts;
    logic [1:0]  eops;
    logic [3:0]  resid;
    logic        hunt_end;
    logic [4:0]  dbits;
  } vec_t;

  localparam vec_t VECS [7] = '{
    '{64'h7E557E,       7'd24, 1'b0, 4'd2, 4'd1, 8'h55, 2'd0, 2'd0, 4'd0, 1'b0, 5'd8},
    '{64'hFDDF7E,       7'd25, 1'b0, 4'd2, 4'd1, 8'hFF, 2'd0, 2'd0, 4'd0, 1'b0, 5'd8},
    '{64'h7FA53C7E,     7'd31, 1'b0, 4'd1, 4'd1, 8'h3C, 2'd1, 2'd0, 4'd0, 1'b1, 5'd14},
    '{64'h7FA53C7E,     7'd31, 1'b1, 4'd1, 4'd1, 8'h3C, 2'd0, 2'd1, 4'd0, 1'b1, 5'd14},
    '{64'h7E817E7E7E,   7'd40, 1'b0, 4'd4, 4'd1, 8'h81, 2'd0, 2'd0, 4'd0, 1'b0, 5'd8},
    '{64'h3F50F7E,      7'd27, 1'b0, 4'd2, 4'd1, 8'h0F, 2'd0, 2'd0, 4'd3, 1'b0, 5'd11},
    '{64'h7EC37E55,     7'd32, 1'b0, 4'd2, 4'd1, 8'hC3, 2'd0, 2'd0, 4'd0, 1'b0, 5'd8}
  };

  int errors = 0;
  int checks = 0;
  int n_flag, n_byte, n_ab, n_eop, n_dbit, last_res;
  logic [7:0] last_byte;
  logic prev_abort;

  task automatic check(input logic ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic clear_tally();
    n_flag = 0; n_byte = 0; n_ab = 0; n_eop = 0; n_dbit = 0; last_res = 0;
    last_byte = 8'h00; prev_abort = 1'b0;
  endtask

  task automatic do_reset(input logic lm);
    rst_n = 1'b0; in_valid = 1'b0; byte_ready = 1'b1; loop_mode = lm;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    clear_tally();
  endtask

  // Called at a falling edge; returns at the falling edge after the bit is taken.
  task automatic send_bit(input logic b);
    in_bit = b;
    in_valid = 1'b1;
    while (!in_ready) @(negedge clk);
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    if (flag_seen) n_flag++;
    if (byte_valid && byte_ready) begin n_byte++; last_byte = byte_data; end
    if (abort_active && !prev_abort) n_ab++;
    prev_abort = abort_active;
    if (eop_seen) n_eop++;
    if (dbit_valid) n_dbit++;
    if (residue_valid) last_res = int'(residue_bits);
  endtask

  task automatic send_bits(input logic [63:0] val, input int n);
    for (int i = 0; i < n; i++) send_bit(val[i]);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: run did not finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    // R1: reset state
    do_reset(1'b0);
    @(negedge clk);
    check(hunting == 1'b1,    "R1 hunting after reset",    int'(hunting), 1);
    check(in_ready == 1'b1,   "R1 in_ready after reset",   int'(in_ready), 1);
    check(byte_valid == 1'b0, "R1 byte_valid after reset", int'(byte_valid), 0);
    check(abort_active == 1'b0 && flag_seen == 1'b0 && eop_seen == 1'b0 && dbit_valid == 1'b0,
          "R1 pulses quiet after reset", int'(abort_active), 0);

    // Framed stream vectors
    for (int v = 0; v < 7; v++) begin
      vec_t tv;
      tv = VECS[v];
      do_reset(tv.loop);
      send_bits(tv.stream, int'(tv.nbits));
      check(n_flag == int'(tv.flags),  "R3 flag count",          n_flag, int'(tv.flags));
      check(n_byte == int'(tv.bytes),  "R7 byte count",          n_byte, int'(tv.bytes));
      check(last_byte == tv.last,      "R7 byte value",          int'(last_byte), int'(tv.last));
      check(n_ab == int'(tv.aborts),   "R4 abort rises",         n_ab, int'(tv.aborts));
      check(n_eop == int'(tv.eops),    "R5 end-of-poll pulses",  n_eop, int'(tv.eops));
      check(last_res == int'(tv.resid),"R8 residue bits",        last_res, int'(tv.resid));
      check(hunting == tv.hunt_end,    "R6 hunting at end",      int'(hunting), int'(tv.hunt_end));
      check(n_dbit == int'(tv.dbits),  "R2 R10 destuffed bits",  n_dbit, int'(tv.dbits));
    end

    // R9: back-pressure holds the byte and stalls input
    do_reset(1'b0);
    byte_ready = 1'b0;
    send_bits(64'h7E, 8);
    send_bits(64'h55, 8);
    send_bits(64'h7E, 7);
    check(byte_valid == 1'b1, "R9 byte pending",       int'(byte_valid), 1);
    check(byte_data == 8'h55, "R9 pending byte value", int'(byte_data), 'h55);
    check(in_ready == 1'b0,   "R9 input stalled",      int'(in_ready), 0);
    in_bit = 1'b0; in_valid = 1'b1;
    repeat (3) @(negedge clk);
    check(flag_seen == 1'b0 && byte_valid == 1'b1 && byte_data == 8'h55,
          "R9 nothing consumed while stalled", int'(flag_seen), 0);
    byte_ready = 1'b1;
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    check(flag_seen == 1'b1,  "R9 stalled flag bit taken on release", int'(flag_seen), 1);
    check(byte_valid == 1'b0, "R9 byte taken on release",            int'(byte_valid), 0);

    // R4: long run of ones keeps abort until a zero
    do_reset(1'b0);
    send_bits(64'h7E, 8);
    send_bits(64'h7F, 7);
    check(abort_active == 1'b1 && hunting == 1'b1, "R4 abort at seventh one", int'(abort_active), 1);
    send_bits(64'h7, 3);
    check(abort_active == 1'b1, "R4 abort held on tenth one", int'(abort_active), 1);
    send_bit(1'b0);
    check(abort_active == 1'b0, "R4 zero clears abort", int'(abort_active), 0);
    send_bits(64'h7E, 8);
    check(hunting == 1'b0, "R3 flag ends hunt after abort", int'(hunting), 0);

    // R5: loop mode long run never raises abort
    do_reset(1'b1);
    send_bits(64'h7E, 8);
    send_bits(64'h3FF, 10);
    check(abort_active == 1'b0 && n_eop == 1, "R5 loop mode single end-of-poll", n_eop, 1);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule